// File: doc/BRIEF.md
# Programmable Data-Enable Timing Generator

This block rebuilds a data-enable signal for a video stream from its horizontal sync, vertical sync and pixel clock. A pixel index restarts at each leading edge of horizontal sync, and a line index restarts at each leading edge of vertical sync. The generated enable is high while both indices fall inside an active rectangle. That rectangle is set by a horizontal start, a vertical start, an active width and an active height, all written through a small parallel register port. For interlaced sources, a field flag flips at every vertical edge, and in the second field the vertical start is moved down by a programmable number of lines.

A select bit picks what drives the `de_out` port. It is either the generated enable or the enable received alongside the video. The received enable goes through the same two-clock pipeline, so both sources keep the same alignment. When marker generation is on, the block also emits two one-clock pulses for every active line. One comes the clock before the first active pixel and one comes on the last active pixel. A later stage that inserts embedded timing codes uses them.

All geometry and mode settings are written into a staging copy. They move into the working copy only on a vertical sync leading edge, so a frame is never built from a mix of old and new values. The sync polarity settings are the one exception and apply at once.

Top module: `de_timing_gen`

## Requirements
- R1: After reset, `de_out`, `sav_pulse`, `eav_pulse` and `field_out` are 0. The settings start as: select 0, markers off, interlace off, offset 0, horizontal start 260 (0x104), vertical start 24, width 1280 (0x500), height 720 (0x2D0), both syncs active-high.
- R2: Register map. Address 0 holds the select bit in [0], marker enable in [1], interlace enable in [2] and the field offset in [5:3]. Address 1 is the horizontal start [9:0], address 2 the vertical start [5:0], address 3 the width [11:0] and address 4 the height [11:0]. A write reaches the staging copy only. The working copy loads from the staging copy at the next vertical sync leading edge, and a write on that same clock lands after the load.
- R3: The pixel index is 0 in the cycle after the clock edge that first samples a horizontal leading edge. It then rises by 1 per clock and holds at 8191. The generated enable is true for pixel indices in [hstart, hstart+width), and `de_out` shows it two clocks later.
- R4: The line index is 0 after a vertical leading edge and rises by 1 on each later horizontal leading edge. The generated enable also needs the line index to be in [vstart, vstart+height).
- R5: At each vertical leading edge the field flag toggles if the newly loaded interlace enable is 1, and is cleared otherwise. In field 1, vstart is the vertical start plus the offset. In field 0, vstart is the vertical start.
- R6: With the select bit 1, `de_out` carries the generated enable. With it 0, `de_out` is `de_in` delayed by two clocks.
- R7: With marker enable 1, `sav_pulse` is high for one clock just before the generated enable rises at `de_out`, and `eav_pulse` is high on the last clock it is high. With marker enable 0, neither pulses. The markers follow the generated enable whatever the select bit is.
- R8: Address 5 sets the horizontal polarity in bit [0] and the vertical polarity in bit [1]. 1 makes a rising edge the leading edge and 0 a falling edge. These take effect on the next clock, without waiting for vertical sync.
- R9: A width or height of 0 gives no generated enable and no markers. With both starts at 0, the first pixel of line 0 is active.
- R10: Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, polarity set by register |
| vsync_in | input | 1 | Vertical sync, polarity set by register |
| de_in | input | 1 | Received data enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Register write data |
| de_out | output | 1 | Selected data enable |
| sav_pulse | output | 1 | Pulse one clock before the first active pixel |
| eav_pulse | output | 1 | Pulse on the last active pixel |
| field_out | output | 1 | Current field flag |

## Verification
The bench first runs the power-on geometry with the generated source selected. This shows the reset values are right, because a wrong start or size moves the enable edges by a known number of clocks. It then runs many small random rectangles, with random starts, widths, interlace offsets and marker settings. Each geometry is held for two frames, so both fields and the staged loading are exercised.

Directed frames cover several cases. A random `de_in` with the received source selected separates the two sources. A zero width and zero starts test the window edges. Settings written in the middle of a frame must not change that frame. Writes to unused addresses must have no effect. Inverted sync polarities must find the same edges as the active-high setting.

// File: rtl/de_timing_pkg.sv
package de_timing_pkg;

    // Field widths of the programmable settings
    parameter int HDLY_W = 10;
    parameter int VDLY_W = 6;
    parameter int SIZE_W = 12;
    parameter int IOFS_W = 3;
    parameter int ADDR_W = 3;

    // Derived widths
    localparam int DATA_W  = SIZE_W;
    localparam int CNT_W   = SIZE_W + 1;
    localparam int OFS_LSB = 3;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Power-on settings
    localparam logic [HDLY_W-1:0] HDLY_RST = HDLY_W'(260);
    localparam logic [VDLY_W-1:0] VDLY_RST = VDLY_W'(24);
    localparam logic [SIZE_W-1:0] WIDTH_RST = SIZE_W'(1280);
    localparam logic [SIZE_W-1:0] HEIGHT_RST = SIZE_W'(720);

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_HDLY   = 3'd1,
        SEL_VDLY   = 3'd2,
        SEL_WIDTH  = 3'd3,
        SEL_HEIGHT = 3'd4,
        SEL_POL    = 3'd5
    } reg_sel_e;

    // Settings as written by software
    typedef struct packed {
        logic              force_gen;
        logic              mark_en;
        logic              ilace_en;
        logic [IOFS_W-1:0] ofs;
        logic [HDLY_W-1:0] hdly;
        logic [VDLY_W-1:0] vdly;
        logic [SIZE_W-1:0] width;
        logic [SIZE_W-1:0] height;
    } cfg_t;

    // Settings in the form the window compare uses
    typedef struct packed {
        logic             force_gen;
        logic             mark_en;
        logic [CNT_W-1:0] h_beg;
        logic [CNT_W-1:0] h_end;
        logic [CNT_W-1:0] v_beg0;
        logic [CNT_W-1:0] v_end0;
        logic [CNT_W-1:0] v_beg1;
        logic [CNT_W-1:0] v_end1;
    } bounds_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.force_gen = 1'b0;
        c.mark_en   = 1'b0;
        c.ilace_en  = 1'b0;
        c.ofs       = '0;
        c.hdly      = HDLY_RST;
        c.vdly      = VDLY_RST;
        c.width     = WIDTH_RST;
        c.height    = HEIGHT_RST;
        return c;
    endfunction

    function automatic bounds_t make_bounds(cfg_t c);
        bounds_t b;
        b.force_gen = c.force_gen;
        b.mark_en   = c.mark_en;
        b.h_beg     = CNT_W'(c.hdly);
        b.h_end     = CNT_W'(c.hdly) + CNT_W'(c.width);
        b.v_beg0    = CNT_W'(c.vdly);
        b.v_end0    = CNT_W'(c.vdly) + CNT_W'(c.height);
        b.v_beg1    = CNT_W'(c.vdly) + CNT_W'(c.ofs);
        b.v_end1    = CNT_W'(c.vdly) + CNT_W'(c.ofs) + CNT_W'(c.height);
        return b;
    endfunction

    function automatic logic in_span(logic [CNT_W-1:0] v,
                                     logic [CNT_W-1:0] lo,
                                     logic [CNT_W-1:0] hi);
        return (v >= lo) && (v < hi);
    endfunction

endpackage

// File: rtl/de_sync_edge.sv
module de_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic active_high,
    output logic lead
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= raw;
    end

    always_comb begin
        if (active_high) lead = raw & ~prev;
        else             lead = ~raw & prev;
    end

endmodule

// File: rtl/de_cfg_regs.sv
module de_cfg_regs
    import de_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              reload,
    output bounds_t           act,
    output logic              ilace_pend,
    output logic              hs_pol,
    output logic              vs_pol
);
    cfg_t stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg    <= cfg_reset();
            act    <= make_bounds(cfg_reset());
            hs_pol <= 1'b1;
            vs_pol <= 1'b1;
        end else begin
            if (reload) act <= make_bounds(stg);
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    SEL_CTRL: begin
                        stg.force_gen <= wr_data[0];
                        stg.mark_en   <= wr_data[1];
                        stg.ilace_en  <= wr_data[2];
                        stg.ofs       <= wr_data[OFS_LSB +: IOFS_W];
                    end
                    SEL_HDLY:   stg.hdly   <= wr_data[HDLY_W-1:0];
                    SEL_VDLY:   stg.vdly   <= wr_data[VDLY_W-1:0];
                    SEL_WIDTH:  stg.width  <= wr_data;
                    SEL_HEIGHT: stg.height <= wr_data;
                    SEL_POL: begin
                        hs_pol <= wr_data[0];
                        vs_pol <= wr_data[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ilace_pend = stg.ilace_en;

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(act));

endmodule

// File: rtl/de_raster.sv
module de_raster
    import de_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_lead,
    input  logic             vs_lead,
    input  logic             ilace_pend,
    output logic [CNT_W-1:0] pix,
    output logic [CNT_W-1:0] line,
    output logic             field
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix   <= '0;
            line  <= '0;
            field <= 1'b0;
        end else begin
            if (hs_lead)             pix <= '0;
            else if (pix != CNT_MAX) pix <= pix + 1'b1;

            if (vs_lead)                         line <= '0;
            else if (hs_lead && line != CNT_MAX) line <= line + 1'b1;

            if (vs_lead) field <= ilace_pend ? ~field : 1'b0;
        end
    end

    // R3
    pix_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hs_lead |=> (pix == '0));

    // R4
    line_zero_chk: assert property (@(posedge clk) disable iff (rst)
        vs_lead |=> (line == '0));

    // R5
    field_still_chk: assert property (@(posedge clk) disable iff (rst)
        !vs_lead |=> $stable(field));

endmodule

// File: rtl/de_window_out.sv
module de_window_out
    import de_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] pix,
    input  logic [CNT_W-1:0] line,
    input  logic             field,
    input  bounds_t          bnd,
    input  logic             de_in,
    output logic             de_out,
    output logic             sav,
    output logic             eav
);
    logic [CNT_W-1:0] v_lo, v_hi;
    logic             win, win_q, dein_q;

    always_comb begin
        v_lo = field ? bnd.v_beg1 : bnd.v_beg0;
        v_hi = field ? bnd.v_end1 : bnd.v_end0;
        win  = in_span(pix, bnd.h_beg, bnd.h_end) && in_span(line, v_lo, v_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= 1'b0;
            dein_q <= 1'b0;
            de_out <= 1'b0;
            sav    <= 1'b0;
            eav    <= 1'b0;
        end else begin
            win_q  <= win;
            dein_q <= de_in;
            de_out <= bnd.force_gen ? win_q : dein_q;
            sav    <= bnd.mark_en & win & ~win_q;
            eav    <= bnd.mark_en & win_q & ~win;
        end
    end

    // R7
    mark_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sav, eav}));

    // R7
    sav_then_de_chk: assert property (@(posedge clk) disable iff (rst)
        (sav && bnd.force_gen) |=> de_out);

    // R7
    eav_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (eav && bnd.force_gen) |=> !de_out);

endmodule

// File: rtl/de_timing_gen.sv
module de_timing_gen
    import de_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              de_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              de_out,
    output logic              sav_pulse,
    output logic              eav_pulse,
    output logic              field_out
);
    localparam int NUM_SYNC = 2;

    logic [NUM_SYNC-1:0] raw, pol, lead;
    logic                hs_pol, vs_pol, ilace_pend;
    bounds_t             act;
    logic [CNT_W-1:0]    pix, line;
    logic                field;

    assign raw = {vsync_in, hsync_in};
    assign pol = {vs_pol, hs_pol};

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        de_sync_edge u_edge (
            .clk        (clk),
            .rst        (rst),
            .raw        (raw[g]),
            .active_high(pol[g]),
            .lead       (lead[g])
        );
    end

    de_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .reload    (lead[1]),
        .act       (act),
        .ilace_pend(ilace_pend),
        .hs_pol    (hs_pol),
        .vs_pol    (vs_pol)
    );

    de_raster u_raster (
        .clk       (clk),
        .rst       (rst),
        .hs_lead   (lead[0]),
        .vs_lead   (lead[1]),
        .ilace_pend(ilace_pend),
        .pix       (pix),
        .line      (line),
        .field     (field)
    );

    de_window_out u_win (
        .clk   (clk),
        .rst   (rst),
        .pix   (pix),
        .line  (line),
        .field (field),
        .bnd   (act),
        .de_in (de_in),
        .de_out(de_out),
        .sav   (sav_pulse),
        .eav   (eav_pulse)
    );

    assign field_out = field;

endmodule

// File: tb/de_timing_gen_test.sv
module de_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        hsync_in, vsync_in, de_in, cfg_we;
    logic [2:0]  cfg_addr;
    logic [11:0] cfg_wdata;
    logic        de_out, sav_pulse, eav_pulse, field_out;

    always #5 clk = ~clk;

    de_timing_gen uut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .de_in(de_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .de_out(de_out), .sav_pulse(sav_pulse), .eav_pulse(eav_pulse),
        .field_out(field_out)
    );

    typedef struct {
        bit force_gen, mk, il;
        int ofs, hd, vd, w, h;
    } bcfg_t;

    typedef struct {
        bit win, mk, frc, dein;
    } hent_t;

    bcfg_t stg, act;
    bit    pol_h, pol_v, fld, prev_h, prev_v;
    int    bpix, bline;
    hent_t h0, h1, h2;
    int    total = 0, bad = 0;
    string tag = "R1";
    int    wa[8], wd[8];
    int    nw = 0;
    bit    done = 0;

    function automatic bcfg_t dflt();
        bcfg_t c;
        c.force_gen = 0; c.mk = 0; c.il = 0; c.ofs = 0;
        c.hd = 260; c.vd = 24; c.w = 1280; c.h = 720;
        return c;
    endfunction

    function automatic bit in_win(bcfg_t c, bit f, int px, int ln);
        int vs;
        vs = c.vd + (f ? c.ofs : 0);
        return (px >= c.hd) && (px < c.hd + c.w) && (ln >= vs) && (ln < vs + c.h);
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic apply_wr(int a, int d);
        case (a)
            0: begin
                stg.force_gen = d[0]; stg.mk = d[1]; stg.il = d[2]; stg.ofs = (d >> 3) & 7;
            end
            1: stg.hd = d & 1023;
            2: stg.vd = d & 63;
            3: stg.w  = d & 4095;
            4: stg.h  = d & 4095;
            5: begin pol_h = d[0]; pol_v = d[1]; end
            default: ;  // R10: unused addresses leave the model untouched
        endcase
    endtask

    task automatic step(bit hs, bit vs, bit dein, bit we, int a, int d);
        bit he, ve;
        he = hs & ~prev_h;
        ve = vs & ~prev_v;
        prev_h = hs;
        prev_v = vs;
        hsync_in  = pol_h ? hs : ~hs;
        vsync_in  = pol_v ? vs : ~vs;
        de_in     = dein;
        cfg_we    = we;
        cfg_addr  = a[2:0];
        cfg_wdata = d[11:0];
        @(posedge clk);
        if (ve) begin
            act   = stg;
            fld   = act.il ? ~fld : 1'b0;
            bline = 0;
        end else if (he) begin
            bline++;
        end
        if (he) bpix = 0;
        else if (bpix < 8191) bpix++;
        if (we) apply_wr(a, d);
        h2 = h1;
        h1 = h0;
        h0.win  = in_win(act, fld, bpix, bline);
        h0.mk   = act.mk;
        h0.frc  = act.force_gen;
        h0.dein = dein;
        @(negedge clk);
        chk(tag, "de_out", int'(de_out), int'(h1.frc ? h2.win : h1.dein));
        chk(tag, "sav_pulse", int'(sav_pulse), int'(h1.mk & h1.win & ~h2.win));
        chk(tag, "eav_pulse", int'(eav_pulse), int'(h1.mk & h2.win & ~h1.win));
        chk(tag, "field_out", int'(field_out), int'(fld));
    endtask

    task automatic qwr(int a, int d);
        wa[nw] = a;
        wd[nw] = d;
        nw++;
    endtask

    task automatic qcfg(bit frc, bit mk, bit il, int ofs, int hd, int vd, int w, int h);
        qwr(0, int'(frc) | (int'(mk) << 1) | (int'(il) << 2) | (ofs << 3));
        qwr(1, hd);
        qwr(2, vd);
        qwr(3, w);
        qwr(4, h);
    endtask

    task automatic frame(int nlines, int period, bit rnd);
        for (int l = 0; l < nlines; l++) begin
            for (int p = 0; p < period; p++) begin
                bit we;
                int k;
                k  = p - 10;
                we = (l == 1) && (k >= 0) && (k < nw);
                step(p < 4, (l == 0) && (p < 2), rnd ? bit'($urandom % 2) : 1'b0,
                     we, we ? wa[k] : 0, we ? wd[k] : 0);
            end
        end
        nw = 0;
    endtask

    task automatic frame_auto(bit rnd);
        bcfg_t c;
        c = stg;
        frame(c.vd + c.ofs + c.h + 3, c.hd + c.w + 16 + int'($urandom % 8), rnd);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        string tags[4];
        void'($urandom(32'd2024));
        tags = '{"R3", "R4", "R5", "R7"};
        hsync_in = 0; vsync_in = 0; de_in = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        rst = 1;
        stg = dflt(); act = dflt();
        pol_h = 1; pol_v = 1; fld = 0; prev_h = 0; prev_v = 0;
        bpix = 0; bline = 0;
        h0 = '{0, 0, 0, 0}; h1 = h0; h2 = h0;
        repeat (4) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R1: outputs idle straight after reset
        chk("R1", "reset de_out", int'(de_out), 0);
        chk("R1", "reset sav_pulse", int'(sav_pulse), 0);
        chk("R1", "reset eav_pulse", int'(eav_pulse), 0);
        chk("R1", "reset field_out", int'(field_out), 0);

        // R2: select write made mid-frame; this frame still follows de_in (R6)
        tag = "R2";
        qwr(0, 1);
        frame(3, 40, 1);

        // R1: power-on geometry with the generated source; de_in is noise
        tag = "R1";
        qcfg(1, 1, 0, 0, 3, 1, 5, 2);
        qwr(6, 4095);
        qwr(7, 4095);
        frame(26, 1600, 1);

        // R10: unused addresses had no effect on this geometry
        tag = "R10";
        frame_auto(1);
        frame_auto(1);

        // R9: zero width, then zero height, then both starts at zero
        tag = "R9";
        qcfg(1, 1, 0, 0, 4, 1, 0, 3);
        frame_auto(1);
        qcfg(1, 1, 0, 0, 4, 1, 6, 0);
        frame_auto(1);
        qcfg(1, 1, 0, 0, 0, 0, 7, 2);
        frame_auto(1);
        frame_auto(1);

        // R5: largest field offset, both fields
        tag = "R5";
        qcfg(1, 1, 1, 7, 2, 2, 6, 3);
        frame_auto(1);
        frame_auto(1);
        frame_auto(1);
        frame_auto(1);

        // R3 R4 R5 R7: random geometries, two frames each
        for (int i = 0; i < 24; i++) begin
            tag = tags[i % 4];
            qcfg(($urandom % 4) != 0, ($urandom % 4) != 0, bit'($urandom % 2),
                 int'($urandom % 8), int'($urandom % 16), int'($urandom % 4),
                 int'($urandom % 21), 1 + int'($urandom % 6));
            frame_auto(1);
            frame_auto(1);
        end
        frame_auto(1);

        // R8: both syncs switched to active-low while idle
        tag = "R8";
        repeat (3) step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 5, 0);
        repeat (3) step(0, 0, 0, 0, 0, 0);
        qcfg(1, 1, 1, 3, 5, 1, 9, 4);
        frame_auto(1);
        frame_auto(1);
        frame_auto(1);

        // R6: received source selected again while markers stay on
        tag = "R6";
        qcfg(0, 1, 0, 0, 2, 1, 8, 3);
        frame_auto(1);
        frame_auto(1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule